// File: doc/BRIEF.md
# PCI Configuration Status and Command Word

This block holds the 32-bit configuration word of a PCI-style function that joins a command half-word (bits 15:0) with a status half-word (bits 31:16). The bus protocol engine, parity checker and error pin drivers sit outside. They report what happened as single-cycle event pulses. The block turns those pulses into sticky error flags, keeps the software-writable command bits, and presents the whole word on a combinational read port.

Configuration software writes the word through a byte-enabled write port. In the command half, enabled bytes update the writable bits. In the status half, a 1 clears the matching error flag. Two status fields are wired to fixed values. A registered interrupt line reports the parity-detected flag whenever an external enable allows it.

Top module: `pci_cfg_stcmd`

## Requirements
- R1: After reset the read word is 0x0280_0000. Bits 26:25 read 01, bit 23 reads 1, and every other bit reads 0. The interrupt output is 0.
- R2: A one-cycle event pulse sets its flag, which reads 1 in the cycle after the pulse. The flags are: bit 31 parity detected, bit 30 system error signalled, bit 29 master abort received, bit 28 target abort received, bit 27 target abort signalled.
- R3: A set flag stays at 1 for any length of time and through repeated events, until a configuration write clears it.
- R4: A write with byte enable 3 high clears each flag whose data bit is 1. Flags whose data bit is 0 are left alone. A write with byte enable 3 low leaves every flag alone. Writing 1 to a flag that is already 0 leaves it at 0.
- R5: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up at 1.
- R6: The parity-detected flag (bit 31) is set even when the parity-response command bit (bit 6) is 0.
- R7: The master data parity flag (bit 24) is set only when three conditions hold together: the master-role input is 1, a read-PERR or write-PERR pulse arrives, and command bit 6 is 1.
- R8: A master abort pulse marked as a special cycle does not set bit 29.
- R9: Bits 26:25 always read 01 and bit 23 always reads 1, whatever is written to them. Status bits 22:16 always read 0.
- R10: Command bits 9:0 are read/write. Byte enable 0 covers bits 7:0 and byte enable 1 covers bits 9:8. Bits 15:10 always read 0. A byte whose enable is low keeps its value.
- R11: The interrupt output equals the registered AND of the bit 31 flag and the enable input. It changes one cycle after either of them changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_be | input | 4 | Byte enables of the write |
| cfg_wr_data | input | 32 | Write data (1 clears a status flag) |
| cfg_rd_data | output | 32 | Current configuration word |
| ev_par_err | input | 1 | Parity error detected pulse |
| ev_serr_sig | input | 1 | System error signalled pulse |
| ev_mabort | input | 1 | Master abort termination pulse |
| ev_mabort_spcl | input | 1 | Marks the aborted transaction as a special cycle |
| ev_tabort_rcv | input | 1 | Target abort received as master |
| ev_tabort_sig | input | 1 | Target abort signalled as target |
| ev_perr_mrd | input | 1 | PERR driven by this master on a read |
| ev_perr_mwr | input | 1 | PERR seen from the target on a master write |
| is_master | input | 1 | Device currently acts as bus master |
| perr_irq_en | input | 1 | Parity interrupt enable |
| perr_irq | output | 1 | Parity error interrupt level |

## Verification
The bench builds the block with its default parameters. These are DEVSEL code 01, fast back-to-back capable 1, a writable-command mask of 0x03FF and a two-stage reset synchronizer. With these values the fixed fields, the boundary between writable and reserved command bits, and both byte lanes of the command half can all be observed through the read port. Because the writable mask ends inside byte 1, a lane write with all ones shows which bits are reserved. Events, clearing writes and their collisions are each driven on cycle boundaries, which exposes the ordering between set and clear.

// File: rtl/pci_stcmd_pkg.sv
package pci_stcmd_pkg;
  localparam int unsigned CFG_W      = 32;
  localparam int unsigned CMD_W      = 16;
  localparam int unsigned BE_W       = CFG_W / 8;
  localparam int unsigned NUM_FLAGS  = 6;

  localparam int unsigned FL_PAR_DET   = 0;
  localparam int unsigned FL_SERR_SIG  = 1;
  localparam int unsigned FL_MABT_RCV  = 2;
  localparam int unsigned FL_TABT_RCV  = 3;
  localparam int unsigned FL_TABT_SIG  = 4;
  localparam int unsigned FL_MDATA_PAR = 5;

  localparam int unsigned FLAG_POS [NUM_FLAGS] = '{31, 30, 29, 28, 27, 24};

  localparam int unsigned DEVSEL_LSB    = 25;
  localparam int unsigned FB2B_CAP_BIT  = 23;
  localparam int unsigned CMD_PERR_RESP = 6;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/stcmd_rst_sync.sv
module stcmd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/stcmd_event_qual.sv
module stcmd_event_qual
  import pci_stcmd_pkg::*;
(
  input  logic      ev_par_err,
  input  logic      ev_serr_sig,
  input  logic      ev_mabort,
  input  logic      ev_mabort_spcl,
  input  logic      ev_tabort_rcv,
  input  logic      ev_tabort_sig,
  input  logic      ev_perr_mrd,
  input  logic      ev_perr_mwr,
  input  logic      is_master,
  input  logic      perr_resp,
  output flag_vec_t set_vec
);
  always_comb begin
    set_vec               = '0;
    // Parity detection does not depend on the response bit.
    set_vec[FL_PAR_DET]   = ev_par_err;
    set_vec[FL_SERR_SIG]  = ev_serr_sig;
    // Special cycles never end in a reported master abort.
    set_vec[FL_MABT_RCV]  = ev_mabort & ~ev_mabort_spcl;
    set_vec[FL_TABT_RCV]  = ev_tabort_rcv;
    set_vec[FL_TABT_SIG]  = ev_tabort_sig;
    // Master data parity needs role, a PERR source and the response bit.
    set_vec[FL_MDATA_PAR] = is_master & (ev_perr_mrd | ev_perr_mwr) & perr_resp;
  end
endmodule

// File: rtl/stcmd_flag_bank.sv
module stcmd_flag_bank
  import pci_stcmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  flag_vec_t clr_vec,
  output flag_vec_t flags
);
  flag_vec_t flag_q;
  flag_vec_t flag_d;
  logic      flag_en;

  always_comb begin
    flag_en = (|set_vec) | (|clr_vec);
    // Set has priority so that no event is lost.
    flag_d  = (flag_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flags = flag_q;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_q[i])
      else $error("flag %0d not set after event", i);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr_vec[i]) |=> flag_q[i])
      else $error("flag %0d dropped without clear", i);
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flag_q[i])
      else $error("flag %0d not cleared", i);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && !set_vec[i]) |=> !flag_q[i])
      else $error("flag %0d set without event", i);
  end
endmodule

// File: rtl/stcmd_cmd_reg.sv
module stcmd_cmd_reg #(
  parameter int unsigned         WIDTH = 16,
  parameter logic [WIDTH-1:0]    WMASK = 16'h03FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [WIDTH/8-1:0]   wr_be,
  input  logic [WIDTH-1:0]     wr_data,
  output logic [WIDTH-1:0]     cmd_q
);
  localparam int unsigned LANES = WIDTH / 8;

  logic [WIDTH-1:0] cmd_d;
  logic             cmd_we;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (wr_en && wr_be[l]) cmd_d[l*8 +: 8] = wr_data[l*8 +: 8] & WMASK[l*8 +: 8];
      else                   cmd_d[l*8 +: 8] = cmd_q[l*8 +: 8];
    end

    p_lane_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_be[l]) |=> $stable(cmd_q[l*8 +: 8]))
      else $error("command lane %0d changed without enable", l);
  end

  assign cmd_we = wr_en & (|wr_be);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_we) cmd_q <= cmd_d;
  end
endmodule

// File: rtl/pci_cfg_stcmd.sv
module pci_cfg_stcmd
  import pci_stcmd_pkg::*;
#(
  parameter logic [1:0]       DEVSEL_CODE = 2'b01,
  parameter logic             FB2B_CAP    = 1'b1,
  parameter logic [CMD_W-1:0] CMD_WMASK   = 16'h03FF,
  parameter int unsigned      RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [BE_W-1:0]  cfg_wr_be,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic             ev_par_err,
  input  logic             ev_serr_sig,
  input  logic             ev_mabort,
  input  logic             ev_mabort_spcl,
  input  logic             ev_tabort_rcv,
  input  logic             ev_tabort_sig,
  input  logic             ev_perr_mrd,
  input  logic             ev_perr_mwr,
  input  logic             is_master,
  input  logic             perr_irq_en,
  output logic             perr_irq
);
  localparam int unsigned CMD_BE = CMD_W / 8;

  logic             rst_sync_n;
  logic [CMD_W-1:0] cmd_q;
  flag_vec_t        set_vec;
  flag_vec_t        clr_vec;
  flag_vec_t        flags;
  logic             irq_d;
  logic             irq_q;
  logic [CFG_W-1:0] flag_word_mask;
  logic             unused_wbits;

  stcmd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stcmd_cmd_reg #(.WIDTH(CMD_W), .WMASK(CMD_WMASK)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_wr_en),
    .wr_be   (cfg_wr_be[CMD_BE-1:0]),
    .wr_data (cfg_wr_data[CMD_W-1:0]),
    .cmd_q   (cmd_q)
  );

  stcmd_event_qual u_qual (
    .ev_par_err     (ev_par_err),
    .ev_serr_sig    (ev_serr_sig),
    .ev_mabort      (ev_mabort),
    .ev_mabort_spcl (ev_mabort_spcl),
    .ev_tabort_rcv  (ev_tabort_rcv),
    .ev_tabort_sig  (ev_tabort_sig),
    .ev_perr_mrd    (ev_perr_mrd),
    .ev_perr_mwr    (ev_perr_mwr),
    .is_master      (is_master),
    .perr_resp      (cmd_q[CMD_PERR_RESP]),
    .set_vec        (set_vec)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
    assign clr_vec[i] = cfg_wr_en & cfg_wr_be[FLAG_POS[i]/8] & cfg_wr_data[FLAG_POS[i]];
  end

  stcmd_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags)
  );

  always_comb begin
    flag_word_mask = '0;
    for (int i = 0; i < NUM_FLAGS; i++) flag_word_mask[FLAG_POS[i]] = 1'b1;
  end

  assign unused_wbits = ^{cfg_wr_data[CFG_W-1:CMD_W] & ~flag_word_mask[CFG_W-1:CMD_W],
                          cfg_wr_be[BE_W-2:CMD_BE]};

  always_comb begin
    cfg_rd_data                              = '0;
    cfg_rd_data[CMD_W-1:0]                   = cmd_q;
    cfg_rd_data[DEVSEL_LSB +: 2]             = DEVSEL_CODE;
    cfg_rd_data[FB2B_CAP_BIT]                = FB2B_CAP;
    for (int i = 0; i < NUM_FLAGS; i++) cfg_rd_data[FLAG_POS[i]] = flags[i];
  end

  always_comb begin
    irq_d = flags[FL_PAR_DET] & perr_irq_en;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign perr_irq = irq_q;

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    perr_irq |-> $past(flags[FL_PAR_DET] && perr_irq_en))
    else $error("interrupt without enabled parity flag");

  p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flags[FL_PAR_DET] && perr_irq_en) |=> perr_irq)
    else $error("interrupt missing");

  p_mdp_qual_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(flags[FL_MDATA_PAR]) |-> $past(is_master && cmd_q[CMD_PERR_RESP]))
    else $error("master data parity set without qualification");

  p_mabort_spcl_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_mabort && ev_mabort_spcl && !flags[FL_MABT_RCV]) |=> !flags[FL_MABT_RCV])
    else $error("special cycle abort set master abort flag");

  p_reserved_cmd_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_q & ~CMD_WMASK) == '0)
    else $error("reserved command bit set");
endmodule

// File: tb/pci_cfg_stcmd_tb_top.sv
module pci_cfg_stcmd_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_be = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic [7:0]  ev = '0;
  logic        is_master = 1'b0;
  logic        perr_irq_en = 1'b0;
  logic        perr_irq;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  localparam logic [31:0] RST_WORD = 32'h0280_0000;
  // Event bit order in ev
  localparam int E_PAR = 0, E_SERR = 1, E_MABT = 2, E_SPCL = 3,
                 E_TRCV = 4, E_TSIG = 5, E_PRD = 6, E_PWR = 7;

  always #2 clk = ~clk;

  pci_cfg_stcmd dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_be      (cfg_wr_be),
    .cfg_wr_data    (cfg_wr_data),
    .cfg_rd_data    (cfg_rd_data),
    .ev_par_err     (ev[E_PAR]),
    .ev_serr_sig    (ev[E_SERR]),
    .ev_mabort      (ev[E_MABT]),
    .ev_mabort_spcl (ev[E_SPCL]),
    .ev_tabort_rcv  (ev[E_TRCV]),
    .ev_tabort_sig  (ev[E_TSIG]),
    .ev_perr_mrd    (ev[E_PRD]),
    .ev_perr_mwr    (ev[E_PWR]),
    .is_master      (is_master),
    .perr_irq_en    (perr_irq_en),
    .perr_irq       (perr_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [7:0] m);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic cfg_write(logic [31:0] d, logic [3:0] be);
    cfg_wr_en = 1'b1; cfg_wr_data = d; cfg_wr_be = be;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = '0; cfg_wr_be = '0;
  endtask

  task automatic clear_flags();
    cfg_write(32'hF900_0000, 4'b1000);
  endtask

  task automatic t_reset();
    chk("R1 reset word", cfg_rd_data, RST_WORD);
    chk("R1 reset irq", {31'd0, perr_irq}, 32'd0);
  endtask

  task automatic t_event_set();
    int pos [5] = '{31, 30, 29, 28, 27};
    int src [5] = '{E_PAR, E_SERR, E_MABT, E_TRCV, E_TSIG};
    for (int i = 0; i < 5; i++) begin
      pulse(8'(1 << src[i]));
      chk("R2 event sets flag", cfg_rd_data, RST_WORD | (32'd1 << pos[i]));
      clear_flags();
      chk("R2 cleared between events", cfg_rd_data, RST_WORD);
    end
  endtask

  task automatic t_sticky();
    pulse(8'(1 << E_TSIG));
    repeat (10) @(negedge clk);
    chk("R3 flag held", cfg_rd_data, RST_WORD | 32'h0800_0000);
    pulse(8'(1 << E_TSIG));
    chk("R3 repeat event", cfg_rd_data, RST_WORD | 32'h0800_0000);
    clear_flags();
  endtask

  task automatic t_w1c();
    pulse(8'(1 << E_PAR) | 8'(1 << E_SERR) | 8'(1 << E_MABT));
    chk("R4 three flags set", cfg_rd_data, RST_WORD | 32'hE000_0000);
    cfg_write(32'h4000_0000, 4'b1000);
    chk("R4 clear only bit 30", cfg_rd_data, RST_WORD | 32'hA000_0000);
    cfg_write(32'h0000_0000, 4'b1000);
    chk("R4 zero write no effect", cfg_rd_data, RST_WORD | 32'hA000_0000);
    cfg_write(32'hFF00_0000, 4'b0111);
    chk("R4 byte enable 3 low", cfg_rd_data, RST_WORD | 32'hA000_0000);
    cfg_write(32'h1000_0000, 4'b1000);
    chk("R4 one to clear flag", cfg_rd_data, RST_WORD | 32'hA000_0000);
    clear_flags();
    chk("R4 all cleared", cfg_rd_data, RST_WORD);
  endtask

  task automatic t_collision();
    ev = 8'(1 << E_PAR);
    cfg_wr_en = 1'b1; cfg_wr_data = 32'h8000_0000; cfg_wr_be = 4'b1000;
    @(negedge clk);
    ev = '0; cfg_wr_en = 1'b0; cfg_wr_data = '0; cfg_wr_be = '0;
    chk("R5 set beats clear", cfg_rd_data, RST_WORD | 32'h8000_0000);
    clear_flags();
  endtask

  task automatic t_pe_resp();
    pulse(8'(1 << E_PAR));
    chk("R6 parity flag with response off", cfg_rd_data, RST_WORD | 32'h8000_0000);
    clear_flags();
  endtask

  task automatic t_mdp();
    is_master = 1'b1;
    pulse(8'(1 << E_PRD));
    chk("R7 response bit off", {31'd0, cfg_rd_data[24]}, 32'd0);
    cfg_write(32'h0000_0040, 4'b0001);
    is_master = 1'b0;
    pulse(8'(1 << E_PRD) | 8'(1 << E_PWR));
    chk("R7 not master", {31'd0, cfg_rd_data[24]}, 32'd0);
    is_master = 1'b1;
    pulse(8'(1 << E_SERR));
    chk("R7 no perr source", {31'd0, cfg_rd_data[24]}, 32'd0);
    pulse(8'(1 << E_PWR));
    chk("R7 write perr sets", cfg_rd_data, RST_WORD | 32'h4100_0040);
    clear_flags();
    pulse(8'(1 << E_PRD));
    chk("R7 read perr sets", cfg_rd_data, RST_WORD | 32'h0100_0040);
    clear_flags();
    cfg_write(32'h0, 4'b0001);
    is_master = 1'b0;
    chk("R7 restored", cfg_rd_data, RST_WORD);
  endtask

  task automatic t_mabort_spcl();
    pulse(8'(1 << E_MABT) | 8'(1 << E_SPCL));
    chk("R8 special cycle abort", cfg_rd_data, RST_WORD);
    pulse(8'(1 << E_MABT));
    chk("R8 normal abort", cfg_rd_data, RST_WORD | 32'h2000_0000);
    clear_flags();
  endtask

  task automatic t_constants();
    cfg_write(32'hFFFF_FFFF, 4'b1111);
    chk("R9 constants after ones", cfg_rd_data, 32'h0280_03FF);
    cfg_write(32'h0000_0000, 4'b1111);
    chk("R9 constants after zeros", cfg_rd_data, RST_WORD);
  endtask

  task automatic t_cmd_rw();
    cfg_write(32'h0000_FFFF, 4'b0001);
    chk("R10 low lane", cfg_rd_data, RST_WORD | 32'h0000_00FF);
    cfg_write(32'h0000_FFFF, 4'b0010);
    chk("R10 high lane reserved zero", cfg_rd_data, RST_WORD | 32'h0000_03FF);
    cfg_write(32'h0000_0000, 4'b0010);
    chk("R10 high lane cleared", cfg_rd_data, RST_WORD | 32'h0000_00FF);
    cfg_write(32'h0000_0155, 4'b0011);
    chk("R10 both lanes", cfg_rd_data, RST_WORD | 32'h0000_0155);
    cfg_write(32'h0000_0000, 4'b0011);
  endtask

  task automatic t_irq();
    perr_irq_en = 1'b0;
    pulse(8'(1 << E_PAR));
    @(negedge clk);
    chk("R11 masked", {31'd0, perr_irq}, 32'd0);
    perr_irq_en = 1'b1;
    @(negedge clk);
    chk("R11 enable rises", {31'd0, perr_irq}, 32'd1);
    perr_irq_en = 1'b0;
    @(negedge clk);
    chk("R11 enable falls", {31'd0, perr_irq}, 32'd0);
    perr_irq_en = 1'b1;
    @(negedge clk);
    clear_flags();
    chk("R11 one cycle after clear", {31'd0, perr_irq}, 32'd1);
    @(negedge clk);
    chk("R11 after clear", {31'd0, perr_irq}, 32'd0);
    pulse(8'(1 << E_PAR));
    chk("R11 lag after event", {31'd0, perr_irq}, 32'd0);
    @(negedge clk);
    chk("R11 raised after event", {31'd0, perr_irq}, 32'd1);
    perr_irq_en = 1'b0;
    clear_flags();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_event_set();
    t_sticky();
    t_w1c();
    t_collision();
    t_pe_resp();
    t_mdp();
    t_mabort_spcl();
    t_constants();
    t_cmd_rw();
    t_irq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule